// File: doc/BRIEF.md
# Paged RAM Window Address Mapper

This block turns a 16-bit local CPU address into a 23-bit global RAM address. One 4KB slice of the local map, 0x1000 to 0x1FFF, is a movable window. An 8-bit page index register chooses which 4KB block of global RAM appears in that window. Two further 4KB slices, 0x2000 to 0x2FFF and 0x3000 to 0x3FFF, are hardwired to the two highest pages, 0xFE and 0xFF.

The page register comes out of reset at 0xFD. The three windows therefore form one linear 12KB RAM region before software changes anything. The register can be read and written at any time through a small strobe interface.

The mapping path is purely combinational. From a local address and a valid strobe it produces three outputs:
- the global address;
- a RAM hit flag;
- an alias flag, raised when page 0 is selected in the movable window, because page 0 shares its global addresses with the register space.

A size parameter can mark the low part of the global RAM range as unimplemented. This covers configurations with less than 12KB of RAM.

Top module: `pram_window_map`

## Requirements
- R1: After reset the page register reads back 0xFD on `reg_rdata`.
- R2: A write with `reg_wr` high updates the page register at the next rising clock edge; translations in the write cycle itself still use the previous page, and the register holds its value in cycles without a write.
- R3: For a valid local address in 0x1000..0x1FFF (local bits 15:12 equal to 1) the global address is {3'b000, page[7:0], local[11:0]}: page in bits 19:12, offset in bits 11:0, bits 22:20 zero.
- R4: A valid local address in 0x2000..0x2FFF (bits 15:12 equal to 2) maps with page 0xFE in bits 19:12 whatever the register holds.
- R5: A valid local address in 0x3000..0x3FFF (bits 15:12 equal to 3) maps with page 0xFF in bits 19:12 whatever the register holds.
- R6: When `map_valid` is low or the local address lies outside 0x1000..0x3FFF, `map_hit` and `map_alias` are 0 and `map_gaddr` is 0.
- R7: `map_alias` is 1 exactly when a valid access falls in the movable window while the page register holds 0x00.
- R8: `map_hit` is 1 for a valid windowed access only if global bits 19:0 are at or above 2^20 minus the implemented RAM size in bytes; with 8KB implemented, page 0xFD misses while pages 0xFE and 0xFF hit.
- R9: Out of reset, local 0x1000..0x3FFF translates to the contiguous global range 0x0FD000..0x0FFFFF with the hit flag set on a full-size configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Page register write strobe |
| reg_wdata | input | 8 | Page value to write |
| reg_rdata | output | 8 | Current page register value |
| map_valid | input | 1 | Local address is valid |
| map_addr | input | 16 | Local CPU address |
| map_gaddr | output | 23 | Translated global address |
| map_hit | output | 1 | Access lands in implemented RAM |
| map_alias | output | 1 | Movable window aliases register space (page 0) |

## Verification
The bench builds two instances that share every input. The first uses the default parameters, so the whole 1MB page range counts as implemented. The second is built with 8KB implemented, which places the start of implemented RAM at global 0x0FE000. The default instance reaches the reset linearity of R9 and the page-zero alias. The small instance reaches the missing-RAM case, where the reset page 0xFD misses while the two fixed windows still hit.

// File: rtl/pram_pkg.sv
`timescale 1ns/1ps
package pram_pkg;
   typedef enum logic [1:0] {
      WIN_NONE  = 2'd0,
      WIN_PAGED = 2'd1,
      WIN_FIXED = 2'd2
   } win_kind_t;
endpackage

// File: rtl/pram_page_reg.sv
`timescale 1ns/1ps
module pram_page_reg #(
   parameter int PAGE_W     = 8,
   parameter int RESET_PAGE = 253
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [PAGE_W-1:0] wdata,
   output logic [PAGE_W-1:0] page
);
   localparam logic [PAGE_W-1:0] RST_VAL = PAGE_W'(RESET_PAGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  page <= RST_VAL;
      else if (wr) page <= wdata;
   end
endmodule

// File: rtl/pram_window_decode.sv
`timescale 1ns/1ps
module pram_window_decode
   import pram_pkg::*;
#(
   parameter int LOCAL_AW  = 16,
   parameter int OFFSET_W  = 12,
   parameter int PAGE_W    = 8,
   parameter int PAGED_WIN = 1,
   parameter int NUM_FIXED = 2,
   parameter int TOP_PAGE  = 255
) (
   input  logic                valid,
   input  logic [LOCAL_AW-1:0] addr,
   input  logic [PAGE_W-1:0]   reg_page,
   output win_kind_t           kind,
   output logic [PAGE_W-1:0]   sel_page
);
   localparam int WIN_W = LOCAL_AW - OFFSET_W;

   logic [WIN_W-1:0]  win;
   logic              paged_sel;
   logic [NUM_FIXED-1:0] fixed_sel;
   logic [PAGE_W-1:0] fixed_page [NUM_FIXED];

   assign win       = addr[LOCAL_AW-1:OFFSET_W];
   assign paged_sel = valid && (win == WIN_W'(PAGED_WIN));

   // Fixed windows follow the movable one and alias the highest pages.
   for (genvar i = 0; i < NUM_FIXED; i++) begin : g_fixed
      assign fixed_sel[i]  = valid && (win == WIN_W'(PAGED_WIN + 1 + i));
      assign fixed_page[i] = PAGE_W'(TOP_PAGE - (NUM_FIXED - 1 - i));
   end

   always_comb begin
      kind     = WIN_NONE;
      sel_page = '0;
      if (paged_sel) begin
         kind     = WIN_PAGED;
         sel_page = reg_page;
      end else begin
         for (int j = 0; j < NUM_FIXED; j++) begin
            if (fixed_sel[j]) begin
               kind     = WIN_FIXED;
               sel_page = fixed_page[j];
            end
         end
      end
   end
endmodule

// File: rtl/pram_gaddr_build.sv
`timescale 1ns/1ps
module pram_gaddr_build
   import pram_pkg::*;
#(
   parameter int OFFSET_W   = 12,
   parameter int PAGE_W     = 8,
   parameter int ZERO_PAD   = 3,
   parameter int IMPL_BYTES = 1 << 20,
   localparam int GLOBAL_AW = ZERO_PAD + PAGE_W + OFFSET_W
) (
   input  win_kind_t             kind,
   input  logic [PAGE_W-1:0]     sel_page,
   input  logic [OFFSET_W-1:0]   offset,
   output logic [GLOBAL_AW-1:0]  gaddr,
   output logic                  hit,
   output logic                  alias_reg
);
   localparam int RAM_AW     = PAGE_W + OFFSET_W;
   localparam int RAM_SPAN   = 1 << RAM_AW;
   localparam int IMPL_START = RAM_SPAN - IMPL_BYTES;

   logic [RAM_AW-1:0] ram_addr;
   logic              in_impl;
   logic              mapped;

   assign ram_addr = {sel_page, offset};
   assign mapped   = (kind != WIN_NONE);

   if (IMPL_BYTES == RAM_SPAN) begin : g_full
      assign in_impl = 1'b1;
   end else begin : g_partial
      assign in_impl = (ram_addr >= RAM_AW'(IMPL_START));
   end

   assign gaddr     = mapped ? {{ZERO_PAD{1'b0}}, ram_addr} : '0;
   assign hit       = mapped && in_impl;
   assign alias_reg = (kind == WIN_PAGED) && (sel_page == '0);
endmodule

// File: rtl/pram_window_map.sv
`timescale 1ns/1ps
module pram_window_map
   import pram_pkg::*;
#(
   parameter int LOCAL_AW   = 16,
   parameter int OFFSET_W   = 12,
   parameter int PAGE_W     = 8,
   parameter int ZERO_PAD   = 3,
   parameter int PAGED_WIN  = 1,
   parameter int NUM_FIXED  = 2,
   parameter int TOP_PAGE   = 255,
   parameter int RESET_PAGE = 253,
   parameter int IMPL_BYTES = 1 << 20,
   localparam int GLOBAL_AW = ZERO_PAD + PAGE_W + OFFSET_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [PAGE_W-1:0]     reg_wdata,
   output logic [PAGE_W-1:0]     reg_rdata,
   input  logic                  map_valid,
   input  logic [LOCAL_AW-1:0]   map_addr,
   output logic [GLOBAL_AW-1:0]  map_gaddr,
   output logic                  map_hit,
   output logic                  map_alias
);
   localparam int WIN_COUNT = 1 << (LOCAL_AW - OFFSET_W);

   if (OFFSET_W >= LOCAL_AW)                  begin : g_bad_off  $error("OFFSET_W must be below LOCAL_AW"); end
   if (PAGE_W + OFFSET_W > 30)                begin : g_bad_span $error("page plus offset too wide"); end
   if (PAGED_WIN + NUM_FIXED >= WIN_COUNT)    begin : g_bad_win  $error("windows exceed local map"); end
   if (NUM_FIXED < 1 || TOP_PAGE >= (1 << PAGE_W) || TOP_PAGE < NUM_FIXED - 1)
                                              begin : g_bad_fix  $error("fixed page setup invalid"); end
   if (RESET_PAGE >= (1 << PAGE_W))           begin : g_bad_rst  $error("reset page out of range"); end
   if (IMPL_BYTES < 1 || IMPL_BYTES > (1 << (PAGE_W + OFFSET_W)))
                                              begin : g_bad_impl $error("implemented size out of range"); end

   win_kind_t         kind;
   logic [PAGE_W-1:0] sel_page;

   pram_page_reg #(
      .PAGE_W    (PAGE_W),
      .RESET_PAGE(RESET_PAGE)
   ) u_page_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (reg_wr),
      .wdata(reg_wdata),
      .page (reg_rdata)
   );

   pram_window_decode #(
      .LOCAL_AW (LOCAL_AW),
      .OFFSET_W (OFFSET_W),
      .PAGE_W   (PAGE_W),
      .PAGED_WIN(PAGED_WIN),
      .NUM_FIXED(NUM_FIXED),
      .TOP_PAGE (TOP_PAGE)
   ) u_decode (
      .valid   (map_valid),
      .addr    (map_addr),
      .reg_page(reg_rdata),
      .kind    (kind),
      .sel_page(sel_page)
   );

   pram_gaddr_build #(
      .OFFSET_W  (OFFSET_W),
      .PAGE_W    (PAGE_W),
      .ZERO_PAD  (ZERO_PAD),
      .IMPL_BYTES(IMPL_BYTES)
   ) u_build (
      .kind     (kind),
      .sel_page (sel_page),
      .offset   (map_addr[OFFSET_W-1:0]),
      .gaddr    (map_gaddr),
      .hit      (map_hit),
      .alias_reg(map_alias)
   );
endmodule

// File: rtl/pram_window_map_chk.sv
`timescale 1ns/1ps
module pram_window_map_chk #(
   parameter int LOCAL_AW   = 16,
   parameter int OFFSET_W   = 12,
   parameter int PAGE_W     = 8,
   parameter int ZERO_PAD   = 3,
   parameter int PAGED_WIN  = 1,
   parameter int NUM_FIXED  = 2,
   parameter int TOP_PAGE   = 255,
   parameter int RESET_PAGE = 253
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  reg_wr,
   input logic [PAGE_W-1:0]                     reg_wdata,
   input logic [PAGE_W-1:0]                     reg_rdata,
   input logic                                  map_valid,
   input logic [LOCAL_AW-1:0]                   map_addr,
   input logic [ZERO_PAD+PAGE_W+OFFSET_W-1:0]   map_gaddr,
   input logic                                  map_hit,
   input logic                                  map_alias
);
   localparam int WIN_W = LOCAL_AW - OFFSET_W;
   localparam int RAM_AW = PAGE_W + OFFSET_W;

   logic [WIN_W-1:0] win;
   logic             in_any;
   assign win    = map_addr[LOCAL_AW-1:OFFSET_W];
   assign in_any = map_valid && (win >= WIN_W'(PAGED_WIN)) && (win <= WIN_W'(PAGED_WIN + NUM_FIXED));

   a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> reg_rdata == PAGE_W'(RESET_PAGE));

   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> reg_rdata == $past(reg_wdata));

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(reg_rdata));

   a_r3_paged_compose: assert property (@(posedge clk) disable iff (!rst_n)
      (map_valid && win == WIN_W'(PAGED_WIN)) |->
         (map_gaddr[OFFSET_W +: PAGE_W] == reg_rdata) &&
         (map_gaddr[OFFSET_W-1:0] == map_addr[OFFSET_W-1:0]) &&
         (map_gaddr[RAM_AW +: ZERO_PAD] == '0));

   a_r4_first_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (map_valid && win == WIN_W'(PAGED_WIN + 1)) |->
         map_gaddr[OFFSET_W +: PAGE_W] == PAGE_W'(TOP_PAGE - NUM_FIXED + 1));

   a_r5_last_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (map_valid && win == WIN_W'(PAGED_WIN + NUM_FIXED)) |->
         map_gaddr[OFFSET_W +: PAGE_W] == PAGE_W'(TOP_PAGE));

   a_r6_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_any |-> (!map_hit && !map_alias && map_gaddr == '0));

   a_r7_alias_cause: assert property (@(posedge clk) disable iff (!rst_n)
      map_alias |-> (map_valid && win == WIN_W'(PAGED_WIN) && reg_rdata == '0));
endmodule

bind pram_window_map pram_window_map_chk #(
   .LOCAL_AW  (LOCAL_AW),
   .OFFSET_W  (OFFSET_W),
   .PAGE_W    (PAGE_W),
   .ZERO_PAD  (ZERO_PAD),
   .PAGED_WIN (PAGED_WIN),
   .NUM_FIXED (NUM_FIXED),
   .TOP_PAGE  (TOP_PAGE),
   .RESET_PAGE(RESET_PAGE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .map_valid(map_valid),
   .map_addr (map_addr),
   .map_gaddr(map_gaddr),
   .map_hit  (map_hit),
   .map_alias(map_alias)
);

// File: tb/pram_window_map_bench.sv
`timescale 1ns/1ps
module pram_window_map_bench;
   localparam int SMALL_BYTES = 8192;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic        map_valid = 1'b0;
   logic [15:0] map_addr = '0;
   logic [7:0]  rd_f, rd_s;
   logic [22:0] ga_f, ga_s;
   logic        hit_f, hit_s, al_f, al_s;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [7:0] page_m;

   always #5 clk = ~clk;

   pram_window_map u_pram_window_map (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd_f),
      .map_valid(map_valid), .map_addr(map_addr), .map_gaddr(ga_f), .map_hit(hit_f), .map_alias(al_f));

   pram_window_map #(.IMPL_BYTES(SMALL_BYTES)) u_pram_window_map_small (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd_s),
      .map_valid(map_valid), .map_addr(map_addr), .map_gaddr(ga_s), .map_hit(hit_s), .map_alias(al_s));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [24:0] model(input logic v, input logic [15:0] a,
                                         input logic [7:0] pg, input int impl);
      logic [3:0]  w;
      logic [7:0]  p;
      logic [22:0] g;
      logic        h, al;
      w = a[15:12];
      if (!v || w < 4'd1 || w > 4'd3) return '0;
      p  = (w == 4'd1) ? pg : (w == 4'd2) ? 8'hFE : 8'hFF;
      g  = {3'b000, p, a[11:0]};
      h  = (int'({p, a[11:0]}) >= (1 << 20) - impl);
      al = (w == 4'd1) && (pg == 8'h00);
      return {g, h, al};
   endfunction

   task automatic check_both(input string req);
      logic [24:0] ef, es;
      ef = model(map_valid, map_addr, page_m, 1 << 20);
      es = model(map_valid, map_addr, page_m, SMALL_BYTES);
      chk({req, " gaddr"}, 32'(ga_f), 32'(ef[24:2]));
      chk({req, " hit"},   32'(hit_f), 32'(ef[1]));
      chk({req, " alias"}, 32'(al_f),  32'(ef[0]));
      chk({req, " small gaddr"}, 32'(ga_s), 32'(es[24:2]));
      chk({req, " small hit"},   32'(hit_s), 32'(es[1]));
   endtask

   task automatic apply(input logic v, input logic [15:0] a, input string req);
      @(negedge clk);
      map_valid = v;
      map_addr  = a;
      #1;
      check_both(req);
   endtask

   task automatic write_page(input logic [7:0] val);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = val;
      map_valid = 1'b1;
      map_addr = 16'h1ABC;
      #1;
      check_both("R2 same-cycle old page");
      @(posedge clk);
      page_m = val;
      @(negedge clk);
      reg_wr = 1'b0;
      #1;
      chk("R2 readback", 32'(rd_f), 32'(val));
      chk("R2 readback small", 32'(rd_s), 32'(val));
      check_both("R2 new page in use");
   endtask

   initial begin
      page_m = 8'hFD;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset value during reset", 32'(rd_f), 32'hFD);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R1 reset value", 32'(rd_f), 32'hFD);

      // R9: linear region out of reset, across both window seams
      for (int a = 16'h1000; a < 16'h4000; a += 16'h0FF8) begin
         apply(1'b1, 16'(a), "R9 linear");
         chk("R9 contiguous", 32'(ga_f), 32'h0FD000 + 32'(a - 16'h1000));
         chk("R9 hit", 32'(hit_f), 32'd1);
      end
      apply(1'b1, 16'h1FFF, "R9 seam low");
      chk("R9 seam low value", 32'(ga_f), 32'h0FDFFF);
      apply(1'b1, 16'h2000, "R9 seam high");
      chk("R9 seam high value", 32'(ga_f), 32'h0FE000);

      // R8: small configuration loses page FD but keeps FE and FF
      apply(1'b1, 16'h1800, "R8 small FD");
      chk("R8 small FD miss", 32'(hit_s), 32'd0);
      apply(1'b1, 16'h2000, "R8 small FE");
      chk("R8 small FE hit", 32'(hit_s), 32'd1);
      apply(1'b1, 16'h3FFF, "R8 small FF");

      // R2 and R3
      write_page(8'h42);
      apply(1'b1, 16'h1234, "R3 paged");
      chk("R3 exact", 32'(ga_f), 32'h042234);

      // R4 / R5 independent of register
      apply(1'b1, 16'h2ABC, "R4 fixed FE");
      chk("R4 exact", 32'(ga_f), 32'h0FEABC);
      apply(1'b1, 16'h3123, "R5 fixed FF");
      chk("R5 exact", 32'(ga_f), 32'h0FF123);

      // R7 alias on page 0
      write_page(8'h00);
      apply(1'b1, 16'h1010, "R7 alias");
      chk("R7 alias set", 32'(al_f), 32'd1);
      apply(1'b1, 16'h2010, "R7 no alias in fixed");
      chk("R7 alias clear", 32'(al_f), 32'd0);
      apply(1'b0, 16'h1010, "R7 no alias when invalid");
      write_page(8'hFE);
      apply(1'b1, 16'h1010, "R8 small paged FE");
      chk("R8 small paged FE hit", 32'(hit_s), 32'd1);

      // R6 outside and invalid
      apply(1'b1, 16'h0FFF, "R6 below");
      chk("R6 below zero", 32'(ga_f), 32'd0);
      apply(1'b1, 16'h4000, "R6 above");
      apply(1'b1, 16'hFFFF, "R6 top");
      apply(1'b0, 16'h2222, "R6 invalid");
      chk("R6 invalid hit", 32'(hit_f), 32'd0);

      // Constrained random mix
      for (int i = 0; i < 400; i++) begin
         if (($urandom % 4) == 0) begin
            logic [7:0] v;
            v = (($urandom % 5) == 0) ? 8'h00 : 8'($urandom);
            write_page(v);
         end else begin
            logic [15:0] a;
            a = (($urandom % 4) == 0) ? 16'($urandom) : {2'b00, 14'($urandom)};
            apply(($urandom % 8) != 0, a, "R3-R8 random");
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule